// File: doc/BRIEF.md
# Message-Signalled Interrupt Sender

This block sits inside a peripheral and converts internal interrupt events into single memory-write messages aimed at the host's interrupt window. Software programs a small register set: a control word, a 64-bit target address split into low and high halves, and a 16-bit message data value. The control word contains an enable bit and a field giving log2 of the number of messages that the host granted. When more than one message is granted, the event number is folded into that many low bits of the data value. The host then sees a distinct data word for each event, all derived from the one programmed value.

A compose port loads the address and data registers in one step from a destination ID and a vector. It uses the host interrupt-controller encoding: the address sits in the fixed 0xFEE window with the destination ID in address bits 19:12, and the data word selects edge trigger, assert level and fixed delivery, with the vector in the low byte.

A two-state machine issues the messages. In IDLE it waits for an enabled pending event. When it picks one (transition PICK), it clears that pending bit, freezes address and data into the output registers and moves to SEND. In SEND it holds the write request until the receiver accepts it (transition ACCEPT), then returns to IDLE. If the request is not accepted it stays in SEND (transition STALL).

Top module: `msi_sender`

## Requirements
- R1: After reset `wr_valid` is low, the enable bit, the log2 field, both address halves and the data value read as zero, and the control readback is 0x86. Bit 7 is 1 because the function is 64-bit capable, and bits 3:1 hold log2 of the number of event inputs, which is 3.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register picked by `cfg_sel`, and `cfg_rdata` returns it combinationally. The selector codes are 0 for control, 1 for address low, 2 for address high and 3 for data. Only bits 15:0 of the data register are kept. In the control word, bit 0 is the enable and bits 6:4 are the log2 message count.
- R3: While the enable bit is clear no write request is raised. Events that arrive in that time stay pending, and each one is sent after the enable bit is set.
- R4: A message carries the address {address high, address low}. Its data is zero in bits 31:16, and bits 15:0 are the data register with the low L bits replaced by the folded event number, where L is control bits 6:4.
- R5: The folded event number is the event index ANDed with 2^L−1, so indices above the granted range reuse the low codes.
- R6: Pending events are sent one message at a time, lowest index first.
- R7: While `wr_valid` is high and `wr_ready` is low, the request and its payload stay unchanged. After an accept, `wr_valid` is low for at least one cycle.
- R8: A pulse on `comp_go` sets address low to 0xFEE00000 | dest<<12 and address high to 0. It sets the data to 0x4000 | vector: bit 15 = 0 for edge, bit 14 = 1 for assert, bits 10:8 = 000 for fixed delivery. In the same cycle it takes priority over a register write.
- R9: An event on an index whose message is already being sent pends again and produces one more message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | 32 | Register write value |
| cfg_rdata | output | 32 | Readback of the selected register |
| comp_go | input | 1 | Load address and data from destination and vector |
| comp_dest | input | 8 | Destination ID for composing |
| comp_vec | input | 8 | Vector for composing |
| ev_in | input | 8 | One-cycle event pulses, one per interrupt source |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Receiver accepts the write |
| wr_addr | output | 64 | Message address |
| wr_data | output | 32 | Message data |

## Verification
Two cases can land in the same cycle. In the first, a new event arrives for the index whose message is being sent. The bench holds `wr_ready` low while a message for event 0 waits in SEND, pulses event 0 again, and then expects two identical messages in the scoreboard. In the second, a compose pulse arrives in the same cycle as a software write to the data register. The readback must show the composed value. A later message must carry that value too, with its low bits altered by the granted count.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ALO  = 2'd1,
        SEL_AHI  = 2'd2,
        SEL_DATA = 2'd3
    } sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } st_e;

    localparam logic [11:0] HOST_WINDOW = 12'hFEE;

    // Address in the host interrupt window, destination in bits 19:12.
    function automatic logic [31:0] host_addr(input logic [7:0] dest);
        return {HOST_WINDOW, dest, 12'h000};
    endfunction

    // Edge trigger (bit 15 = 0), assert (bit 14 = 1), fixed delivery (10:8 = 0).
    function automatic logic [15:0] host_data(input logic [7:0] vec);
        return {1'b0, 1'b1, 3'b000, 3'b000, vec};
    endfunction

endpackage

// File: rtl/msi_regs.sv
module msi_regs
    import msi_pkg::*;
#(
    parameter int CAP_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        comp_go,
    input  logic [7:0]  comp_dest,
    input  logic [7:0]  comp_vec,
    output logic        en,
    output logic [2:0]  mme,
    output logic [31:0] addr_lo,
    output logic [31:0] addr_hi,
    output logic [15:0] data
);
    localparam logic [2:0] CAP = 3'(CAP_LOG2);

    sel_e sel;
    logic unused_wbits;

    assign sel = sel_e'(cfg_sel);
    assign unused_wbits = ^{cfg_wdata[31:16], cfg_wdata[15:7], cfg_wdata[3:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            mme     <= 3'd0;
            addr_lo <= '0;
            addr_hi <= '0;
            data    <= '0;
        end else if (comp_go) begin
            addr_lo <= host_addr(comp_dest);
            addr_hi <= '0;
            data    <= host_data(comp_vec);
        end else if (cfg_we) begin
            unique case (sel)
                SEL_CTRL: begin
                    en  <= cfg_wdata[0];
                    mme <= cfg_wdata[6:4];
                end
                SEL_ALO:  addr_lo <= cfg_wdata;
                SEL_AHI:  addr_hi <= cfg_wdata;
                SEL_DATA: data    <= cfg_wdata[15:0];
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: cfg_rdata = {24'h0, 1'b1, mme, CAP, en};
            SEL_ALO:  cfg_rdata = addr_lo;
            SEL_AHI:  cfg_rdata = addr_hi;
            SEL_DATA: cfg_rdata = {16'h0, data};
        endcase
    end

endmodule

// File: rtl/msi_pending.sv
module msi_pending #(
    parameter int NEV  = 8,
    parameter int IDXW = $clog2(NEV)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEV-1:0]  ev,
    input  logic            take,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    logic [NEV-1:0] pend;
    logic [NEV-1:0] clr;

    always_comb begin
        idx = '0;
        for (int i = NEV - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDXW'(i);
        end
    end

    assign any = |pend;

    generate
        for (genvar g = 0; g < NEV; g++) begin : g_clr
            assign clr[g] = take && (idx == IDXW'(g));
        end
    endgenerate

    // A new event wins over the clear of the bit being taken.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | ev;
    end

endmodule

// File: rtl/msi_sender.sv
module msi_sender
    import msi_pkg::*;
#(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [31:0]    cfg_wdata,
    output logic [31:0]    cfg_rdata,
    input  logic           comp_go,
    input  logic [7:0]     comp_dest,
    input  logic [7:0]     comp_vec,
    input  logic [NEV-1:0] ev_in,
    output logic           wr_valid,
    input  logic           wr_ready,
    output logic [63:0]    wr_addr,
    output logic [31:0]    wr_data
);
    localparam int IDXW = (NEV > 1) ? $clog2(NEV) : 1;

    logic            en;
    logic [2:0]      mme;
    logic [31:0]     addr_lo, addr_hi;
    logic [15:0]     data;
    logic            any, take;
    logic [IDXW-1:0] idx;
    logic [15:0]     fold_mask, idx_ext, next_data;
    st_e             state, state_n;

    msi_regs #(.CAP_LOG2(IDXW)) u_regs (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_rdata,
        .comp_go, .comp_dest, .comp_vec,
        .en, .mme, .addr_lo, .addr_hi, .data
    );

    msi_pending #(.NEV(NEV), .IDXW(IDXW)) u_pend (
        .clk, .rst_n, .ev(ev_in), .take, .any, .idx
    );

    assign fold_mask = (16'd1 << mme) - 16'd1;
    assign idx_ext   = 16'(idx);
    assign next_data = (data & ~fold_mask) | (idx_ext & fold_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (en && any) state_n = ST_SEND;
            ST_SEND: if (wr_ready)  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_valid = (state == ST_SEND);
        take     = (state == ST_IDLE) && en && any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (take) begin
            wr_addr <= {addr_hi, addr_lo};
            wr_data <= {16'h0, next_data};
        end
    end

endmodule

// File: rtl/msi_sender_chk.sv
module msi_sender_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        en,
    input logic        comp_go,
    input logic [31:0] addr_lo,
    input logic [31:0] addr_hi
);
    a_r7_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    a_r7_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !wr_valid);

    a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !wr_valid |=> !wr_valid);

    a_r8_compose_window: assert property (@(posedge clk) disable iff (!rst_n)
        comp_go |=> addr_lo[31:20] == 12'hFEE && addr_lo[11:0] == 12'h000 && addr_hi == 32'h0);

endmodule

bind msi_sender msi_sender_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .en(en), .comp_go(comp_go),
    .addr_lo(addr_lo), .addr_hi(addr_hi)
);

// File: tb/sim_msi_sender.sv
module sim_msi_sender;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        comp_go = 1'b0;
    logic [7:0]  comp_dest = '0, comp_vec = '0;
    logic [7:0]  ev_in = '0;
    logic        wr_valid, wr_ready = 1'b1;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;

    int total = 0, bad = 0, seen = 0, ready_mode = 0, cyc = 0;
    logic [95:0] q[$];
    bit done = 0;

    always #2 clk = ~clk;

    msi_sender u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Ready driver: 0 always, 1 one cycle in four, 2 never.
    always @(posedge clk) begin
        #1;
        cyc++;
        wr_ready = (ready_mode == 0) || (ready_mode == 1 && cyc[1:0] == 2'b11);
    end

    // Monitor: pops the scoreboard on each accepted write.
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            seen++;
            if (q.size() == 0) chk(0, "R3/R6 unexpected message", {wr_addr, wr_data}, '0);
            else begin
                logic [95:0] e;
                e = q.pop_front();
                chk({wr_addr, wr_data} == e, "R4/R5/R6 message", {wr_addr, wr_data}, e);
            end
        end
    end

    task automatic cyc1(); @(posedge clk); #1; endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] v);
        cyc1(); cfg_we = 1; cfg_sel = s; cfg_wdata = v;
        cyc1(); cfg_we = 0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string req);
        cyc1(); cfg_sel = s; #0.5;
        chk(cfg_rdata == exp, req, 96'(cfg_rdata), 96'(exp));
    endtask

    task automatic pulse(input logic [7:0] m);
        cyc1(); ev_in = m;
        cyc1(); ev_in = '0;
    endtask

    task automatic push(input logic [63:0] a, input logic [31:0] d);
        q.push_back({a, d});
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && (q.size() != 0 || wr_valid); i++) cyc1();
        chk(q.size() == 0, req, 96'(q.size()), 96'd0);
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 96'(cyc), '0);
        done = 1;
    end

    initial begin
        repeat (3) cyc1();
        rst_n = 1;
        // R1 reset state
        #0.5 chk(wr_valid == 0, "R1 valid", 96'(wr_valid), 96'd0);
        rd(2'd0, 32'h86, "R1 ctrl");
        rd(2'd1, 32'h0, "R1 addr lo");
        rd(2'd3, 32'h0, "R1 data");
        // R2 register writes
        cfg_write(2'd1, 32'hFEE0_1000);
        cfg_write(2'd2, 32'h0000_0001);
        cfg_write(2'd3, 32'hABCD_5000);
        rd(2'd1, 32'hFEE0_1000, "R2 addr lo");
        rd(2'd2, 32'h1, "R2 addr hi");
        rd(2'd3, 32'h5000, "R2 data");
        // R3 disabled, four granted messages
        cfg_write(2'd0, 32'h20);
        rd(2'd0, 32'hA6, "R2 ctrl");
        pulse(8'h0F);
        repeat (12) cyc1();
        chk(seen == 0, "R3 no message while off", 96'(seen), 96'd0);
        for (int i = 0; i < 4; i++) push(64'h1_FEE0_1000, 32'h5000 + i);
        cfg_write(2'd0, 32'h21);
        drain("R3/R6 pending sent after enable");
        // R5 folding of indices above the range
        push(64'h1_FEE0_1000, 32'h5001);
        push(64'h1_FEE0_1000, 32'h5002);
        pulse(8'h60);
        drain("R5 fold mme=2");
        cfg_write(2'd0, 32'h01);
        push(64'h1_FEE0_1000, 32'h5000);
        pulse(8'h80);
        drain("R5 fold mme=0");
        cfg_write(2'd3, 32'h50F5);
        cfg_write(2'd0, 32'h31);
        push(64'h1_FEE0_1000, 32'h50F6);
        pulse(8'h40);
        drain("R4 low three bits replaced");
        // R7 stalled receiver, R6 order
        ready_mode = 1;
        for (int i = 0; i < 8; i++) push(64'h1_FEE0_1000, 32'h50F0 + i);
        pulse(8'hFF);
        drain("R7 stalled handshake");
        // R9 same index while in flight
        ready_mode = 2;
        push(64'h1_FEE0_1000, 32'h50F0);
        push(64'h1_FEE0_1000, 32'h50F0);
        pulse(8'h01);
        repeat (3) cyc1();
        chk(wr_valid == 1, "R7 valid held without ready", 96'(wr_valid), 96'd1);
        pulse(8'h01);
        repeat (3) cyc1();
        ready_mode = 0;
        drain("R9 re-pended event sent again");
        // R8 compose beats a same-cycle data write
        cyc1(); comp_go = 1; comp_dest = 8'h12; comp_vec = 8'h41;
        cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 32'h1234;
        cyc1(); comp_go = 0; cfg_we = 0;
        rd(2'd3, 32'h4041, "R8 data");
        rd(2'd1, 32'hFEE1_2000, "R8 addr lo");
        rd(2'd2, 32'h0, "R8 addr hi");
        cfg_write(2'd0, 32'h11);
        push(64'hFEE1_2000, 32'h4040);
        push(64'hFEE1_2000, 32'h4041);
        pulse(8'h0C);
        drain("R8 composed message with fold");
        chk(seen == 20, "R6 message count", 96'(seen), 96'd20);
        done = 1;
    end

    initial begin
        wait (done);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule